// File: doc/BRIEF.md
# PCI Burst Initiator Data-Phase Sequencer

This block is the initiator half of a conventional PCI memory transaction, cut down to one burst at a time. The local side presents a start address, a direction and a beat count for one clock. The sequencer then runs the bus transaction. It drives one address phase with the memory read or memory write command on the byte-enable lines. It then runs data phases until every beat has moved or the target asks it to give up. On the bus side it drives the transaction-active and initiator-ready strobes, both active low. It watches the target-ready and target-stop strobes, also active low.

Write beats come from a local data word. A take pulse tells the local side to present the next word before the following clock. Read beats are captured from the shared address/data lines and handed out one clock later with a valid pulse. When the transaction ends, a one-clock done pulse reports three things: how many beats were left untransferred, whether the target stopped the burst, and whether the stop came before any beat moved (a retry). Output-enable signals tell the pad logic when the block owns the control, address/data and byte-enable lines.

Top module: `pci_burst_initiator`

## Requirements
- R1: After reset and while idle, `txn_act_n` and `mst_rdy_n` are 1. `busy`, `done`, `ad_oe`, `cbe_oe` and `ctl_oe` are 0.
- R2: A request accepted while idle with a non-zero beat count gives an address phase on the next clock. In it, `txn_act_n`=0, `mst_rdy_n`=1, `ad_out` is the request address and `ad_oe`=1. `cbe_n` carries the command: 4'b0110 for a read, 4'b0111 for a write.
- R3: From the clock after the address phase, `mst_rdy_n` stays 0 until the transaction ends. `cbe_n`=4'b0000 in every data phase. A beat moves only on a clock edge where `mst_rdy_n` and `tgt_rdy_n` are both 0; while `tgt_rdy_n` is 1 the same beat is held.
- R4: During data phases, `txn_act_n` is 0 while more than one beat remains. It is 1 in the data phase of the last beat, which is the same clock in which `mst_rdy_n` is 0. While a transaction runs, `txn_act_n` is never 1 while `mst_rdy_n` is 1.
- R5: In write data phases, `ad_oe`=1 and `ad_out` equals `wr_data`. `wr_take` is 1 exactly in the clocks where a write beat moves.
- R6: In read data phases, `ad_oe`=0. One clock after each read beat moves, `rd_valid` is 1 and `rd_data` holds the `ad_in` value sampled at that beat. At all other times `rd_valid` is 0.
- R7: One clock after the last beat moves, both strobes are 1 and `done` pulses for one clock. It reports `done_remain`=0, `done_stopped`=0 and `done_retry`=0.
- R8: If `tgt_halt_n` is sampled 0 in a data phase, `txn_act_n` is 1 from the next clock. `mst_rdy_n` returns to 1 no later than two clocks after that edge, which is inside the three-clock limit. A beat still moves on that edge if `tgt_rdy_n` is also 0.
- R9: A transaction ended by the target reports `done_stopped`=1. `done_remain` is the number of beats that did not move. `done_retry`=1 only when no beat moved at all.
- R10: A request with a beat count of 0 is ignored. `busy` stays 0 and both strobes stay 1.
- R11: `ctl_oe` is 1 from the address phase through the clock of the `done` pulse, which drives the strobes high for one turnaround clock. It is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request strobe, taken while idle |
| req_addr | input | 32 | Start address of the burst |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_beats | input | BEAT_W | Number of data beats, 0 is ignored |
| wr_data | input | 32 | Write word for the current beat |
| wr_take | output | 1 | Current write word has moved; present the next |
| rd_valid | output | 1 | Read word available on rd_data |
| rd_data | output | 32 | Captured read word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-transaction pulse |
| done_remain | output | BEAT_W | Beats not transferred |
| done_stopped | output | 1 | Transaction ended by target stop |
| done_retry | output | 1 | Target stop with no beat transferred |
| txn_act_n | output | 1 | Transaction-active strobe, active low |
| mst_rdy_n | output | 1 | Initiator-ready strobe, active low |
| tgt_rdy_n | input | 1 | Target-ready strobe, active low |
| tgt_halt_n | input | 1 | Target-stop strobe, active low |
| ctl_oe | output | 1 | Drive enable for the two initiator strobes |
| ad_out | output | 32 | Address/data value driven |
| ad_in | input | 32 | Address/data value sampled |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| cbe_n | output | 4 | Command, then byte enables (active low) |
| cbe_oe | output | 1 | Drive enable for the command/byte-enable lines |

## Verification
The bench goes after the clock in which the transaction-active strobe is released. A sequencer that counts one beat too many or too few would release it a phase early, leaving a beat stranded, or late, so the target sees an extra data phase. Target waits of several clocks check that a data word is held and not skipped; a design that advanced on its own ready alone would drop or duplicate words. Stops are driven in four variants: before any beat (retry), mid-burst with and without a beat moving, and on the last beat. A design with a wrong remaining count, a wrong retry flag or an over-long stop window shows up in the done report or the strobe timing. Single-beat and zero-beat requests probe the edge where the first data phase is already the last, and where no transaction may start.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;
    localparam int CBE_W = 4;
    localparam logic [CBE_W-1:0] CMD_MEM_RD = 4'b0110;
    localparam logic [CBE_W-1:0] CMD_MEM_WR = 4'b0111;
    localparam logic [CBE_W-1:0] BE_ALL_ON  = 4'b0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_LAST
    } phase_e;
endpackage

// File: rtl/pci_init_beatcnt.sv
module pci_init_beatcnt #(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BEAT_W-1:0] load_val,
    input  logic              dec,
    output logic [BEAT_W-1:0] count,
    output logic [BEAT_W-1:0] remain_after,
    output logic              last
);
    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (dec) begin
            cnt_d.cnt = cnt_q.cnt - BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count        = cnt_q.cnt;
    assign last         = (cnt_q.cnt == BEAT_W'(1));
    assign remain_after = cnt_q.cnt - BEAT_W'(dec);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0));
endmodule

// File: rtl/pci_init_datapath.sv
module pci_init_datapath #(
    parameter int DATA_W = 32,
    parameter int CBE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_addr,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              addr_phase,
    input  logic              data_phase,
    input  logic              write_mode,
    input  logic [CBE_W-1:0]  cmd,
    input  logic [CBE_W-1:0]  byte_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              xfer,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [CBE_W-1:0]  cbe_n,
    output logic              cbe_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              rvld;
        logic [DATA_W-1:0] rdat;
    } dp_t;

    dp_t dp_d, dp_q;
    logic rd_beat;

    always_comb begin
        dp_d      = dp_q;
        rd_beat   = data_phase && !write_mode && xfer;
        dp_d.rvld = rd_beat;
        if (capture_addr) begin
            dp_d.addr = req_addr;
        end
        if (rd_beat) begin
            dp_d.rdat = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign ad_out   = addr_phase ? dp_q.addr : wr_data;
    assign ad_oe    = addr_phase || (data_phase && write_mode);
    assign cbe_n    = addr_phase ? cmd : byte_en_n;
    assign cbe_oe   = addr_phase || data_phase;
    assign rd_valid = dp_q.rvld;
    assign rd_data  = dp_q.rdat;

    // R6
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !write_mode && xfer) |=> (rd_valid && rd_data == $past(ad_in)));
endmodule

// File: rtl/pci_burst_initiator.sv
module pci_burst_initiator #(
    parameter int BEAT_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [BEAT_W-1:0] done_remain,
    output logic              done_stopped,
    output logic              done_retry,
    output logic              txn_act_n,
    output logic              mst_rdy_n,
    input  logic              tgt_rdy_n,
    input  logic              tgt_halt_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic [3:0]        cbe_n,
    output logic              cbe_oe
);
    import pci_init_pkg::*;

    typedef struct packed {
        phase_e            st;
        logic              wr;
        logic              any;
        logic              done;
        logic              stopped;
        logic              retry;
        logic [BEAT_W-1:0] remain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept;
    logic              xfer;
    logic              halt_hit;
    logic              finish;
    logic              last;
    logic [BEAT_W-1:0] count;
    logic [BEAT_W-1:0] remain_after;
    logic              addr_phase;
    logic              data_phase;
    logic [CBE_W-1:0]  cmd;

    assign addr_phase = (ctl_q.st == ST_ADDR);
    assign data_phase = (ctl_q.st == ST_DATA) || (ctl_q.st == ST_LAST);
    assign accept     = (ctl_q.st == ST_IDLE) && req_valid && (req_beats != '0);
    assign xfer       = data_phase && !tgt_rdy_n;
    assign halt_hit   = (ctl_q.st == ST_DATA) && !tgt_halt_n;
    assign cmd        = ctl_q.wr ? CMD_MEM_WR : CMD_MEM_RD;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        finish     = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st  = ST_ADDR;
                    ctl_d.wr  = req_write;
                    ctl_d.any = 1'b0;
                end
            end
            ST_ADDR: ctl_d.st = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    ctl_d.any = 1'b1;
                end
                if (halt_hit && !last) begin
                    ctl_d.st = ST_LAST;
                end else if (halt_hit || (xfer && last)) begin
                    finish = 1'b1;
                end
            end
            ST_LAST: finish = 1'b1;
            default: ctl_d.st = ST_IDLE;
        endcase
        if (finish) begin
            ctl_d.st      = ST_IDLE;
            ctl_d.done    = 1'b1;
            ctl_d.remain  = remain_after;
            ctl_d.stopped = halt_hit || (ctl_q.st == ST_LAST);
            ctl_d.retry   = ctl_d.stopped && !(ctl_q.any || xfer);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pci_init_beatcnt #(.BEAT_W(BEAT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .load_val     (req_beats),
        .dec          (xfer),
        .count        (count),
        .remain_after (remain_after),
        .last         (last)
    );

    pci_init_datapath #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_addr (accept),
        .req_addr     (req_addr),
        .addr_phase   (addr_phase),
        .data_phase   (data_phase),
        .write_mode   (ctl_q.wr),
        .cmd          (cmd),
        .byte_en_n    (BE_ALL_ON),
        .wr_data      (wr_data),
        .ad_in        (ad_in),
        .xfer         (xfer),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .cbe_n        (cbe_n),
        .cbe_oe       (cbe_oe),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    assign txn_act_n    = !(addr_phase || ((ctl_q.st == ST_DATA) && !last));
    assign mst_rdy_n    = !data_phase;
    assign busy         = (ctl_q.st != ST_IDLE);
    assign done         = ctl_q.done;
    assign done_remain  = ctl_q.remain;
    assign done_stopped = ctl_q.stopped;
    assign done_retry   = ctl_q.retry;
    assign ctl_oe       = busy || ctl_q.done;
    assign wr_take      = xfer && ctl_q.wr;

    // Stop-window age: clocks spent busy since the target stop was sampled.
    logic [2:0] halt_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_age_q <= '0;
        end else if (halt_hit) begin
            halt_age_q <= 3'd1;
        end else if (!busy) begin
            halt_age_q <= '0;
        end else if (halt_age_q != '0 && halt_age_q != 3'd7) begin
            halt_age_q <= halt_age_q + 3'd1;
        end
    end

    // R2
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!txn_act_n && mst_rdy_n && ad_oe));
    // R4
    act_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txn_act_n) |-> !mst_rdy_n);
    // R3
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_DATA) && tgt_rdy_n && tgt_halt_n) |=> $stable(count));
    // R7
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_DATA) && last && xfer) |=> (txn_act_n && mst_rdy_n && done));
    // R8
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_hit |=> txn_act_n);
    // R8
    halt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_age_q < 3'd3);
    // R9
    retry_implies_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_retry |-> done_stopped);
endmodule

// File: tb/tb_pci_burst_initiator.sv
`timescale 1ns/1ps
module tb_pci_burst_initiator;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic [BW-1:0] req_beats = '0;
    logic [31:0]   wr_data = '0;
    logic          wr_take, rd_valid, busy, done, done_stopped, done_retry;
    logic [31:0]   rd_data, ad_out;
    logic [BW-1:0] done_remain;
    logic          txn_act_n, mst_rdy_n, ctl_oe, ad_oe, cbe_oe;
    logic          tgt_rdy_n = 1'b1;
    logic          tgt_halt_n = 1'b1;
    logic [31:0]   ad_in = '0;
    logic [3:0]    cbe_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pci_burst_initiator #(.BEAT_W(BW), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_beats(req_beats), .wr_data(wr_data),
        .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .done(done), .done_remain(done_remain), .done_stopped(done_stopped),
        .done_retry(done_retry), .txn_act_n(txn_act_n), .mst_rdy_n(mst_rdy_n),
        .tgt_rdy_n(tgt_rdy_n), .tgt_halt_n(tgt_halt_n), .ctl_oe(ctl_oe),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .cbe_n(cbe_n), .cbe_oe(cbe_oe)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int seed, int n);
        return 32'hA500_0000 ^ (32'(seed) << 16) ^ (32'(n) * 32'h0101_0101);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "txn_act_n", txn_act_n, 1);
        chk("R1", "mst_rdy_n", mst_rdy_n, 1);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "oe", {ad_oe, cbe_oe, ctl_oe}, 0);
    endtask

    task automatic t_zero_beats();
        @(negedge clk);
        req_valid = 1'b1; req_beats = '0; req_write = 1'b1; req_addr = 32'hDEAD_0000;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10", "busy", busy, 0);
            chk("R10", "strobes", {txn_act_n, mst_rdy_n}, 2'b11);
            chk("R10", "ctl_oe", ctl_oe, 0);
            @(negedge clk);
        end
    endtask

    // One burst against a bench-side target. stop_at < 0 means no stop.
    task automatic run_burst(string tag, bit wr, int beats, int waits,
                             int stop_at, bit stop_data, int seed);
        int n = 0;
        int wc = 0;
        int stop_cyc = -1;
        bit stop_seen = 0;
        bit rd_pend = 0;
        bit got_done = 0;
        logic [31:0] rd_exp = '0;
        int exp_x;
        exp_x = (stop_at < 0 || stop_at >= beats) ? beats : stop_at + int'(stop_data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_beats = BW'(beats);
        req_addr = 32'h1000_0000 + 32'(seed) * 32'h40;
        wr_data = pat(seed, 0);
        @(negedge clk);
        req_valid = 1'b0; req_beats = '0;
        chk("R2", {tag, " act"}, txn_act_n, 0);
        chk("R2", {tag, " rdy"}, mst_rdy_n, 1);
        chk("R2", {tag, " addr"}, ad_out, 32'h1000_0000 + 32'(seed) * 32'h40);
        chk("R2", {tag, " ad_oe"}, ad_oe, 1);
        chk("R2", {tag, " cmd"}, cbe_n, wr ? 4'b0111 : 4'b0110);
        chk("R11", {tag, " ctl_oe"}, ctl_oe, 1);
        for (int cyc = 0; cyc < 100; cyc++) begin
            @(negedge clk);
            if (!wr) begin
                chk("R6", {tag, " rd_valid"}, rd_valid, rd_pend);
                if (rd_pend) chk("R6", {tag, " rd_data"}, rd_data, rd_exp);
            end
            rd_pend = 0;
            if (done) begin
                got_done = 1;
                break;
            end
            chk("R3", {tag, " rdy low in data"}, mst_rdy_n, 0);
            tgt_rdy_n = 1'b1; tgt_halt_n = 1'b1;
            if (stop_seen) begin
                chk("R8", {tag, " act released"}, txn_act_n, 1);
                chk("R8", {tag, " window"}, (cyc - stop_cyc) <= 2, 1);
                tgt_halt_n = 1'b0;
            end else begin
                chk("R4", {tag, " act vs last"}, txn_act_n, (n == beats - 1));
                chk("R3", {tag, " byte en"}, cbe_n, 4'b0000);
                if (wr) begin
                    chk("R5", {tag, " ad_oe"}, ad_oe, 1);
                    chk("R5", {tag, " wdata"}, ad_out, pat(seed, n));
                end else begin
                    chk("R6", {tag, " ad_oe"}, ad_oe, 0);
                end
                if (stop_at == n) begin
                    tgt_halt_n = 1'b0; tgt_rdy_n = !stop_data;
                    stop_seen = 1; stop_cyc = cyc;
                end else if (wc < waits) begin
                    wc++;
                end else begin
                    tgt_rdy_n = 1'b0; wc = 0;
                end
            end
            ad_in = pat(seed + 7, n);
            #1;
            chk("R5", {tag, " wr_take"}, wr_take, (!tgt_rdy_n) && wr);
            if (!tgt_rdy_n) begin
                if (!wr) begin
                    rd_pend = 1; rd_exp = pat(seed + 7, n);
                end
                n++;
                wr_data = pat(seed, n);
            end
        end
        tgt_rdy_n = 1'b1; tgt_halt_n = 1'b1;
        chk(stop_seen ? "R9" : "R7", {tag, " done seen"}, got_done, 1);
        chk("R7", {tag, " strobes idle"}, {txn_act_n, mst_rdy_n}, 2'b11);
        chk(stop_seen ? "R9" : "R7", {tag, " remain"}, done_remain, beats - exp_x);
        chk(stop_seen ? "R9" : "R7", {tag, " stopped"}, done_stopped, stop_seen);
        chk(stop_seen ? "R9" : "R7", {tag, " retry"}, done_retry, stop_seen && exp_x == 0);
        chk("R3", {tag, " beats moved"}, n, exp_x);
        chk("R11", {tag, " turnaround oe"}, ctl_oe, 1);
        @(negedge clk);
        chk("R7", {tag, " done one clock"}, done, 0);
        chk("R11", {tag, " oe off"}, ctl_oe, 0);
        chk("R1", {tag, " idle oe"}, {ad_oe, cbe_oe}, 0);
        if (!wr) chk("R6", {tag, " rd_valid idle"}, rd_valid, 0);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        run_burst("wr4", 1, 4, 0, -1, 0, 1);
        run_burst("rd3w2", 0, 3, 2, -1, 0, 2);
        run_burst("wr1w1", 1, 1, 1, -1, 0, 3);
        t_zero_beats();
        run_burst("retry", 1, 4, 0, 0, 0, 4);
        run_burst("disc_data", 0, 5, 1, 2, 1, 5);
        run_burst("disc_nodata", 1, 4, 0, 2, 0, 6);
        run_burst("stop_last", 0, 2, 0, 1, 1, 7);
        run_burst("stop_last_nodata", 1, 3, 1, 2, 0, 8);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule